// File: doc/BRIEF.md
# ECC Syndrome Failing-Pin Locator

This block turns a single-bit ECC syndrome code and the physical address of the failing access into three indices: the bit position of the error on the memory data bus, the DIMM that drives that bit (the first DIMM of the group plus a select value), and the connector pin number. Two bus modes are supported. In the wide mode a 64-byte cache line crosses the bus as four 144-bit quadwords, so the failing quadword comes from the address. In the narrow mode the line is a single 144-bit quadword.

The per-board wiring is held in two writable tables that are loaded through a simple write port: a packed DIMM-select map and a pin map, each with two sets. Requests arrive on a valid/ready handshake and pass through two pipeline registers, one per stage. The first stage maps the syndrome and computes the table indices. The second stage reads the tables and registers the result. Every request gives one result, in order. The block returns indices only; label text is left to the consumer. The reset input is asynchronous and active low, and its release is expected to be synchronous to the clock.

Top module: `eccloc_top`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: For a valid single-bit code c the mapped position p is c+16 for c in 0..127, c-121 for 128..136, c-133 for 137..139 and c-140 for 140..144. In narrow mode (`in_wide`=0) `out_bitpos` equals p.
- R3: In wide mode the quadword index q is `in_byte_off[5:4]` (byte offset divided by 16), and `out_bitpos` is (3-q)*144 + p.
- R4: In wide mode let v = 575 - `out_bitpos`. The DIMM select is the 2-bit field at bit position (3 - v mod 4)*2 of DIMM-map byte v/4. `out_dimm` is `in_first` plus the select, modulo 2^DIMM_W.
- R5: In wide mode `in_sym`=1 selects table set 0 and `in_sym`=0 selects set 1. In narrow mode set 0 is always used, whatever `in_sym` is.
- R6: In narrow mode let v = 143 - `out_bitpos`. The select is bit 7 - (v mod 8) of DIMM-map byte v/8, and `out_dimm` is `in_first` plus that bit.
- R7: For a single-bit code `out_pin` is pin-map entry `out_bitpos` of the selected set.
- R8: A code of -1 gives `out_multi`=1, `out_unknown`=0, `out_dimm`=`in_first`, `out_pin`=0 and `out_bitpos`=0.
- R9: A code below -1 or above 144 gives `out_unknown`=1, `out_multi`=0, and 0 on `out_dimm`, `out_pin` and `out_bitpos`.
- R10: A result is held unchanged while `out_valid`=1 and `out_ready`=0. `in_ready` drops only when both stages are full and the output is stalled. Each accepted request produces exactly one result, in order.
- R11: When `tbl_wr_en`=1 at a clock edge, `tbl_wr_data` is written to the pin map (`tbl_wr_pin`=1, address 0..575) or to the DIMM map (`tbl_wr_pin`=0, address 0..143), in set `tbl_wr_set`. Requests accepted after that edge see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| in_syndrome | input | SYN_W | Signed syndrome code, -1 for a multi-bit error |
| in_byte_off | input | 6 | Byte offset of the failing address within its 64-byte line |
| in_wide | input | 1 | 1 = four-quadword bus, 0 = single-quadword bus |
| in_sym | input | 1 | Wide mode only: 1 selects table set 0, 0 selects set 1 |
| in_first | input | DIMM_W | Index of the first DIMM in the failing group |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_unknown | output | 1 | Syndrome code out of range |
| out_multi | output | 1 | Multi-bit error; all DIMMs of the group are suspect |
| out_dimm | output | DIMM_W | Failing DIMM index |
| out_pin | output | PIN_W | Failing pin number |
| out_bitpos | output | 10 | Bit position within the line on the bus |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_pin | input | 1 | 1 = pin map, 0 = DIMM map |
| tbl_wr_set | input | 1 | Table set written |
| tbl_wr_addr | input | 10 | Entry address |
| tbl_wr_data | input | 8 | Entry value |

## Verification
The assertions assume that the tables are not written while a request is inside the pipeline, because the stage-two read would otherwise mix old and new contents. They put no constraint on `out_ready` or on how the producer drives `in_valid`. The stimulus loads every table entry before any request and rewrites entries only after the pipeline has drained. It sweeps every syndrome code from -3 to 146 against every quadword, both symmetry settings and both modes. The sweep runs once with `out_ready` always high and once with a repeating stall pattern, so the hold and back-pressure rules are exercised on live traffic.

// File: rtl/eccloc_pkg.sv
package eccloc_pkg;
  localparam int LINE_QW   = 4;
  localparam int QW_BITS   = 144;
  localparam int LINE_BITS = LINE_QW * QW_BITS;
  localparam int SYN_MAX   = 144;
  localparam int MAP_SETS  = 2;
  localparam int WIDE_ENT  = 2;                       // bits per select entry, wide
  localparam int NARR_ENT  = 1;                       // bits per select entry, narrow
  localparam int DM_DEPTH  = LINE_BITS * WIDE_ENT / 8;
  localparam int PM_DEPTH  = LINE_BITS;
  localparam int TBL_DW    = 8;

  typedef enum logic [1:0] {
    CLS_SINGLE  = 2'd0,
    CLS_MULTI   = 2'd1,
    CLS_UNKNOWN = 2'd2
  } cls_e;
endpackage

// File: rtl/eccloc_posmap.sv
// Classifies a syndrome code and reorders it into bus bit placement.
module eccloc_posmap #(
  parameter int SYN_W = 10,
  parameter int POS_W = 8
) (
  input  logic signed [SYN_W-1:0] code,
  output eccloc_pkg::cls_e        cls,
  output logic [POS_W-1:0]        pos
);
  import eccloc_pkg::*;

  int ci;
  int cu;
  int p;

  always_comb begin
    ci = int'(code);
    cu = int'(code[7:0]);
    if (ci < -1 || ci > SYN_MAX) cls = CLS_UNKNOWN;
    else if (ci == -1)            cls = CLS_MULTI;
    else                          cls = CLS_SINGLE;
    // data bits follow the 16 check/tag bits; check bits fill the low slots
    if (cu < 128)      p = cu + 16;
    else if (cu < 137) p = cu - 121;
    else if (cu < 140) p = cu - 133;
    else               p = cu - 140;
    pos = POS_W'(p);
  end
endmodule

// File: rtl/eccloc_addrgen.sv
// Line offset, packed-map byte index, field shift and set choice.
module eccloc_addrgen #(
  parameter int POS_W = 8,
  parameter int LO_W  = 10,
  parameter int IDX_W = 8
) (
  input  logic             wide,
  input  logic             sym,
  input  logic [1:0]       qword,
  input  logic [POS_W-1:0] pos,
  output logic [LO_W-1:0]  line_off,
  output logic [IDX_W-1:0] byte_idx,
  output logic [2:0]       shift,
  output logic             set_sel
);
  import eccloc_pkg::*;

  localparam int WIDE_PER_BYTE = 8 / WIDE_ENT;
  localparam int NARR_PER_BYTE = 8 / NARR_ENT;

  int lo;
  int inv;

  always_comb begin
    if (wide) begin
      lo      = (LINE_QW - 1 - int'(qword)) * QW_BITS + int'(pos);
      inv     = LINE_BITS - 1 - lo;
      byte_idx = IDX_W'(inv / WIDE_PER_BYTE);
      shift    = 3'((WIDE_PER_BYTE - 1 - inv % WIDE_PER_BYTE) * WIDE_ENT);
      set_sel  = ~sym;
    end else begin
      lo      = int'(pos);
      inv     = QW_BITS - 1 - lo;
      byte_idx = IDX_W'(inv / NARR_PER_BYTE);
      shift    = 3'((NARR_PER_BYTE - 1 - inv % NARR_PER_BYTE) * NARR_ENT);
      set_sel  = 1'b0;
    end
    line_off = LO_W'(lo);
  end
endmodule

// File: rtl/eccloc_maps.sv
// DIMM-select map and pin map, one storage bank per set.
module eccloc_maps #(
  parameter int SETS     = 2,
  parameter int DM_DEPTH = 144,
  parameter int PM_DEPTH = 576,
  parameter int AW       = 10,
  parameter int IDX_W    = 8,
  parameter int LO_W     = 10,
  parameter int DW       = 8,
  localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int DM_AW   = $clog2(DM_DEPTH),
  localparam int PM_AW   = $clog2(PM_DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_pin,
  input  logic [SET_W-1:0] wr_set,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [SET_W-1:0] rd_set,
  input  logic [IDX_W-1:0] rd_byte,
  input  logic [LO_W-1:0]  rd_line,
  output logic [DW-1:0]    dm_q,
  output logic [DW-1:0]    pm_q
);
  logic [DW-1:0] dm_rd [SETS];
  logic [DW-1:0] pm_rd [SETS];

  logic dm_addr_ok;
  logic pm_addr_ok;
  assign dm_addr_ok = (int'(wr_addr) < DM_DEPTH);
  assign pm_addr_ok = (int'(wr_addr) < PM_DEPTH);

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [DW-1:0] dm_mem [DM_DEPTH];
    logic [DW-1:0] pm_mem [PM_DEPTH];
    logic          dm_we;
    logic          pm_we;

    assign dm_we = wr_en && !wr_pin && (wr_set == SET_W'(s)) && dm_addr_ok;
    assign pm_we = wr_en &&  wr_pin && (wr_set == SET_W'(s)) && pm_addr_ok;

    always_ff @(posedge clk) begin
      if (dm_we) dm_mem[wr_addr[DM_AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (pm_we) pm_mem[wr_addr[PM_AW-1:0]] <= wr_data;
    end

    assign dm_rd[s] = (int'(rd_byte) < DM_DEPTH) ? dm_mem[rd_byte[DM_AW-1:0]] : '0;
    assign pm_rd[s] = (int'(rd_line) < PM_DEPTH) ? pm_mem[rd_line[PM_AW-1:0]] : '0;
  end

  assign dm_q = dm_rd[rd_set];
  assign pm_q = pm_rd[rd_set];
endmodule

// File: rtl/eccloc_top.sv
// Two-stage locator: stage 1 maps and indexes, stage 2 reads tables.
module eccloc_top #(
  parameter int SYN_W      = 10,
  parameter int DIMM_W     = 3,
  parameter int PIN_W      = 8,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int QW_LSB    = $clog2(LINE_BYTES / eccloc_pkg::LINE_QW),
  localparam int LO_W      = $clog2(eccloc_pkg::LINE_BITS),
  localparam int IDX_W     = $clog2(eccloc_pkg::DM_DEPTH),
  localparam int POS_W     = $clog2(eccloc_pkg::QW_BITS),
  localparam int TW        = eccloc_pkg::TBL_DW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [SYN_W-1:0] in_syndrome,
  input  logic [OFF_W-1:0]        in_byte_off,
  input  logic                    in_wide,
  input  logic                    in_sym,
  input  logic [DIMM_W-1:0]       in_first,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_unknown,
  output logic                    out_multi,
  output logic [DIMM_W-1:0]       out_dimm,
  output logic [PIN_W-1:0]        out_pin,
  output logic [LO_W-1:0]         out_bitpos,
  input  logic                    tbl_wr_en,
  input  logic                    tbl_wr_pin,
  input  logic                    tbl_wr_set,
  input  logic [LO_W-1:0]         tbl_wr_addr,
  input  logic [TW-1:0]           tbl_wr_data
);
  import eccloc_pkg::*;

  // ---------------- stage 1 combinational ----------------
  cls_e             a_cls;
  logic [POS_W-1:0] a_pos;
  logic [LO_W-1:0]  a_lo;
  logic [IDX_W-1:0] a_idx;
  logic [2:0]       a_shift;
  logic             a_set;

  eccloc_posmap #(.SYN_W(SYN_W), .POS_W(POS_W)) u_posmap (
    .code (in_syndrome),
    .cls  (a_cls),
    .pos  (a_pos)
  );

  eccloc_addrgen #(.POS_W(POS_W), .LO_W(LO_W), .IDX_W(IDX_W)) u_addrgen (
    .wide     (in_wide),
    .sym      (in_sym),
    .qword    (in_byte_off[OFF_W-1:QW_LSB]),
    .pos      (a_pos),
    .line_off (a_lo),
    .byte_idx (a_idx),
    .shift    (a_shift),
    .set_sel  (a_set)
  );

  // ---------------- stage 1 registers ----------------
  logic              s1_v,     s1_v_nx;
  cls_e              s1_cls;
  logic              s1_wide;
  logic              s1_set;
  logic [LO_W-1:0]   s1_lo;
  logic [IDX_W-1:0]  s1_idx;
  logic [2:0]        s1_shift;
  logic [DIMM_W-1:0] s1_first;

  // ---------------- stage 2 registers ----------------
  logic              o_v, o_v_nx;
  logic              o_unk, o_unk_nx;
  logic              o_mul, o_mul_nx;
  logic [DIMM_W-1:0] o_dimm, o_dimm_nx;
  logic [PIN_W-1:0]  o_pin, o_pin_nx;
  logic [LO_W-1:0]   o_pos, o_pos_nx;

  logic s2_adv, s1_adv, load1, load2;

  // ---------------- tables ----------------
  logic [TW-1:0] dm_q, pm_q;

  eccloc_maps #(
    .SETS(MAP_SETS), .DM_DEPTH(DM_DEPTH), .PM_DEPTH(PM_DEPTH),
    .AW(LO_W), .IDX_W(IDX_W), .LO_W(LO_W), .DW(TW)
  ) u_maps (
    .clk     (clk),
    .wr_en   (tbl_wr_en),
    .wr_pin  (tbl_wr_pin),
    .wr_set  (tbl_wr_set),
    .wr_addr (tbl_wr_addr),
    .wr_data (tbl_wr_data),
    .rd_set  (s1_set),
    .rd_byte (s1_idx),
    .rd_line (s1_lo),
    .dm_q    (dm_q),
    .pm_q    (pm_q)
  );

  // ---------------- flow control ----------------
  always_comb begin
    s2_adv  = !o_v || out_ready;
    s1_adv  = !s1_v || s2_adv;
    load1   = s1_adv && in_valid;
    load2   = s2_adv && s1_v;
    s1_v_nx = s1_adv ? in_valid : s1_v;
    o_v_nx  = s2_adv ? s1_v : o_v;
  end

  assign in_ready = s1_adv;

  // ---------------- stage 2 next state ----------------
  logic [TW-1:0] shifted;
  logic [1:0]    sel;

  always_comb begin
    shifted = dm_q >> s1_shift;
    sel     = s1_wide ? shifted[1:0] : {1'b0, shifted[0]};
    o_unk_nx  = 1'b0;
    o_mul_nx  = 1'b0;
    o_dimm_nx = '0;
    o_pin_nx  = '0;
    o_pos_nx  = '0;
    case (s1_cls)
      CLS_SINGLE: begin
        o_dimm_nx = s1_first + DIMM_W'(sel);
        o_pin_nx  = PIN_W'(pm_q);
        o_pos_nx  = s1_lo;
      end
      CLS_MULTI: begin
        o_mul_nx  = 1'b1;
        o_dimm_nx = s1_first;
      end
      default: o_unk_nx = 1'b1;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_cls   <= CLS_UNKNOWN;
      s1_wide  <= 1'b0;
      s1_set   <= 1'b0;
      s1_lo    <= '0;
      s1_idx   <= '0;
      s1_shift <= '0;
      s1_first <= '0;
    end else begin
      s1_v <= s1_v_nx;
      if (load1) begin
        s1_cls   <= a_cls;
        s1_wide  <= in_wide;
        s1_set   <= a_set;
        s1_lo    <= a_lo;
        s1_idx   <= a_idx;
        s1_shift <= a_shift;
        s1_first <= in_first;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_v    <= 1'b0;
      o_unk  <= 1'b0;
      o_mul  <= 1'b0;
      o_dimm <= '0;
      o_pin  <= '0;
      o_pos  <= '0;
    end else begin
      o_v <= o_v_nx;
      if (load2) begin
        o_unk  <= o_unk_nx;
        o_mul  <= o_mul_nx;
        o_dimm <= o_dimm_nx;
        o_pin  <= o_pin_nx;
        o_pos  <= o_pos_nx;
      end
    end
  end

  assign out_valid   = o_v;
  assign out_unknown = o_unk;
  assign out_multi   = o_mul;
  assign out_dimm    = o_dimm;
  assign out_pin     = o_pin;
  assign out_bitpos  = o_pos;
endmodule

// File: rtl/eccloc_checker.sv
module eccloc_checker #(
  parameter int SYN_W  = 10,
  parameter int DIMM_W = 3,
  parameter int PIN_W  = 8,
  parameter int OFF_W  = 6,
  parameter int LO_W   = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic signed [SYN_W-1:0] in_syndrome,
  input logic [OFF_W-1:0]        in_byte_off,
  input logic                    in_wide,
  input logic                    in_sym,
  input logic [DIMM_W-1:0]       in_first,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic                    out_unknown,
  input logic                    out_multi,
  input logic [DIMM_W-1:0]       out_dimm,
  input logic [PIN_W-1:0]        out_pin,
  input logic [LO_W-1:0]         out_bitpos,
  input logic                    tbl_wr_en,
  input logic                    tbl_wr_pin,
  input logic                    tbl_wr_set,
  input logic [LO_W-1:0]         tbl_wr_addr,
  input logic [7:0]              tbl_wr_data
);
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_dimm) && $stable(out_pin)
      && $stable(out_bitpos) && $stable(out_multi) && $stable(out_unknown));

  a_r10_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid && !out_ready);

  a_r8_multi_fields: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_multi |-> !out_unknown && out_pin == '0 && out_bitpos == '0);

  a_r9_unknown_fields: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unknown |-> !out_multi && out_dimm == '0 && out_pin == '0
      && out_bitpos == '0);

  a_r3_bitpos_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_bitpos) < eccloc_pkg::LINE_BITS);
endmodule

bind eccloc_top eccloc_checker #(
  .SYN_W(SYN_W), .DIMM_W(DIMM_W), .PIN_W(PIN_W), .OFF_W(OFF_W), .LO_W(LO_W)
) u_chk (.*);

// File: tb/eccloc_top_bench.sv
`timescale 1ns/1ps
module eccloc_top_bench;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic signed [9:0] in_syndrome;
  logic [5:0]        in_byte_off;
  logic              in_wide;
  logic              in_sym;
  logic [2:0]        in_first;
  logic              out_valid;
  logic              out_ready;
  logic              out_unknown;
  logic              out_multi;
  logic [2:0]        out_dimm;
  logic [7:0]        out_pin;
  logic [9:0]        out_bitpos;
  logic              tbl_wr_en;
  logic              tbl_wr_pin;
  logic              tbl_wr_set;
  logic [9:0]        tbl_wr_addr;
  logic [7:0]        tbl_wr_data;

  always #2 clk = ~clk;

  eccloc_top u_eccloc_top (.*);

  typedef struct {
    bit unk; bit mul; int dimm; int pin; int pos; bit wide; bit sym;
  } exp_t;

  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  int   cyc = 0;
  int   rmode = 0;
  int   dm [2][144];
  int   pm [2][576];
  exp_t q[$];
  bit   prev_stall = 0;
  int   p_dimm, p_pin, p_pos;
  bit   p_unk, p_mul;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic exp_t model(int code, int qw, bit wide, bit sym, int first);
    exp_t e;
    int p, lo, inv, set, b, sel;
    e.wide = wide; e.sym = sym; e.unk = 0; e.mul = 0;
    e.dimm = 0; e.pin = 0; e.pos = 0;
    if (code < -1 || code > 144) begin e.unk = 1; return e; end
    if (code == -1) begin e.mul = 1; e.dimm = first; return e; end
    if (code < 128) p = code + 16;
    else if (code < 137) p = code - 121;
    else if (code < 140) p = code - 133;
    else p = code - 140;
    if (wide) begin
      lo = (3 - qw) * 144 + p; inv = 575 - lo; set = sym ? 0 : 1;
      b = dm[set][inv / 4]; sel = (b >> ((3 - inv % 4) * 2)) & 3;
    end else begin
      lo = p; inv = 143 - lo; set = 0;
      b = dm[0][inv / 8]; sel = (b >> (7 - inv % 8)) & 1;
    end
    e.pos = lo; e.pin = pm[set][lo]; e.dimm = (first + sel) % 8;
    return e;
  endfunction

  task automatic wr(bit pin, bit set, int addr, int data);
    tbl_wr_en = 1; tbl_wr_pin = pin; tbl_wr_set = set;
    tbl_wr_addr = 10'(addr); tbl_wr_data = 8'(data);
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  // called just after a falling edge with inputs driven; returns acceptance
  task automatic tick(output bit acc);
    exp_t e;
    string t;
    out_ready = (rmode == 0) ? 1'b1 : ((cyc % 7) < 4);
    cyc++;
    #1;
    if (prev_stall) begin
      chk("R10 held valid", int'(out_valid), 1);
      chk("R10 held dimm", int'(out_dimm), p_dimm);
      chk("R10 held pin", int'(out_pin), p_pin);
      chk("R10 held bitpos", int'(out_bitpos), p_pos);
      chk("R10 held flags", int'({out_unk_w(), out_multi}), int'({p_unk, p_mul}));
    end
    if (out_valid && out_ready) begin
      if (q.size() == 0) chk("R10 result without request", 1, 0);
      else begin
        e = q.pop_front();
        if (e.unk) t = "R9"; else if (e.mul) t = "R8"; else t = e.wide ? "R3" : "R2";
        chk({t, " unknown flag"}, int'(out_unknown), int'(e.unk));
        chk({t, " multi flag"}, int'(out_multi), int'(e.mul));
        chk({t, " bitpos"}, int'(out_bitpos), e.pos);
        if (e.unk || e.mul) t = e.unk ? "R9" : "R8";
        else if (!e.wide) t = e.sym ? "R5 narrow set" : "R6";
        else t = e.sym ? "R4" : "R5";
        chk({t, " dimm"}, int'(out_dimm), e.dimm);
        chk({(e.unk || e.mul) ? t : "R7", " pin"}, int'(out_pin), e.pin);
      end
    end
    prev_stall = out_valid && !out_ready;
    p_dimm = out_dimm; p_pin = out_pin; p_pos = out_bitpos;
    p_unk = out_unknown; p_mul = out_multi;
    acc = in_valid && in_ready;
    @(negedge clk);
  endtask

  function automatic logic out_unk_w();
    return out_unknown;
  endfunction

  task automatic send(int code, int qw, bit wide, bit sym, int first);
    bit acc;
    int off;
    off = qw * 16 + ((code >= 0) ? (code % 16) : 5);
    in_valid = 1; in_syndrome = 10'(code); in_byte_off = 6'(off);
    in_wide = wide; in_sym = sym; in_first = 3'(first);
    acc = 0;
    while (!acc) tick(acc);
    q.push_back(model(code, qw, wide, sym, first));
    in_valid = 0;
  endtask

  task automatic drain();
    bit acc;
    in_valid = 0;
    for (int i = 0; i < 12; i++) tick(acc);
  endtask

  task automatic sweep();
    int first;
    for (int w = 1; w >= 0; w--)
      for (int s = 0; s < 2; s++)
        for (int qw = 0; qw < 4; qw++)
          for (int code = -3; code <= 146; code++) begin
            if (w == 1) first = (code & 1) ? 4 : 0;
            else first = (code & 1) ? 2 : 0;
            send(code, qw, w[0], s[0], first);
          end
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_syndrome = '0; in_byte_off = '0; in_wide = 0;
    in_sym = 0; in_first = '0; out_ready = 1; tbl_wr_en = 0; tbl_wr_pin = 0;
    tbl_wr_set = 0; tbl_wr_addr = '0; tbl_wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);
    @(negedge clk);

    // R11: load both tables through the write port
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 144; i++) begin
        dm[s][i] = (i * 29 + s * 83 + 17) & 255;
        wr(0, s[0], i, dm[s][i]);
      end
      for (int j = 0; j < 576; j++) begin
        pm[s][j] = (j * 11 + s * 53 + 7) & 255;
        wr(1, s[0], j, pm[s][j]);
      end
    end

    rmode = 0; sweep(); drain();
    rmode = 1; sweep(); drain();

    // R11: rewrite entries, then requests must see the new contents
    dm[0][0] = dm[0][0] ^ 255;
    wr(0, 0, 0, dm[0][0]);
    pm[0][143] = (pm[0][143] + 99) & 255;
    wr(1, 0, 143, pm[0][143]);
    rmode = 0;
    send(127, 0, 0, 0, 0);   // narrow, position 143, map byte 0 bit 7
    send(126, 0, 0, 1, 2);   // narrow, position 142, map byte 0 bit 6
    drain();
    chk("R11 rewritten pin readback", pm[0][143], (((143 * 11 + 7) & 255) + 99) & 255);
    chk("R10 no outstanding requests", q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule